// File: doc/BRIEF.md
# Ternary Clocked Set/Reset Memory Cell

This block is a clocked storage cell that holds one three-valued state (0, 1 or 2). Three level inputs control it: a raising input, a lowering input and a "swing" input that moves the state directly to a chosen value. A three-valued gate input caps the strength of every control input, so a zero gate freezes the cell.

All control levels are active-low in the multi-valued sense. The top level (K-1) means "do nothing" and a lower value asks for a larger action. The cell always presents K registered taps. Tap j is the stored state rotated by j times a rotation setting, modulo K. Downstream logic can therefore read the value directly or cyclically shifted, without any extra arithmetic. At least one control input must rest at the idle level. When none does, the cell keeps its state and flags an error for that update.

All updates happen on the rising clock edge. The reset is synchronous and active-high.

Top module: `tern_rs_cell`

## Requirements
- R1: When `rst` is high at a rising edge, the state becomes 0 and `err_o` becomes 0. Each tap j then reads (j*rot) mod K, using the reduced rotation of R8.
- R2: A control level v is first clamped to K-1, so codes above K-1 count as K-1. It then becomes a request of size (K-1)-v. When all three requests are 0, the state is kept and `err_o` is 0.
- R3: Each request is reduced to min(request, gate), with the gate clamped to K-1. With `gate_i`=0 the state never changes and `err_o` stays 0. With `gate_i`=1 each request is at most 1.
- R4: The raising request adds min(request, K-1-state) to the state. The state never wraps past K-1.
- R5: The lowering request subtracts min(request, state). When the raising and lowering requests are both nonzero, next state = state + min(S, K-1-state) - min(R, state).
- R6: A nonzero swing request m sets the next state to m. It takes priority over the raising and lowering requests.
- R7: When all three gated requests are nonzero, the state is unchanged and `err_o` is 1 for the cycle after that edge. It returns to 0 after the next legal update.
- R8: Tap j, at bits [j*W +: W] of `taps_o`, equals (state + j*rot) mod K. It is registered with the state and uses the `rot_i` value sampled at that edge. A `rot_i` value of K or more is reduced by K.
- R9: Every tap value is always below K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_lvl_i | input | W | Raising control level (K-1 = idle) |
| sr_lvl_i | input | W | Swing control level (K-1 = idle) |
| r_lvl_i | input | W | Lowering control level (K-1 = idle) |
| gate_i | input | W | Gate level; 0 locks, K-1 passes |
| rot_i | input | W | Rotation step for the taps |
| taps_o | output | K*W | Registered rotated copies of the state |
| err_o | output | 1 | Registered illegal-combination flag |

## Verification
The bench drives the cell into both ends of its range and then pushes further. A cell that wrapped instead of saturating would show 0 after a raise from 2, or 2 after a lowering from 0. It combines swing with a raise to confirm that swing wins, and raise with lowering to confirm both are clamped against the current state. It also applies an all-active combination, where a faulty cell would move the state or leave the flag stuck high. Finally, it sweeps the gate through 0 and 1, where a missing min would let full-strength requests through, and sweeps the rotation through 1, 2 and the out-of-range code, where a wrong modulo would produce tap values of 3 or more.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_SWING = 2'd2,
    ACT_BAD   = 2'd3
  } tern_act_e;
endpackage

// File: rtl/tern_gate.sv
module tern_gate #(
  parameter int K = 3,
  parameter int W = $clog2(K)
) (
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] gate_i,
  output logic [W-1:0] req_o
);
  localparam logic [W-1:0] TOP = W'(K-1);
  logic [W-1:0] lvl_c, gate_c, inv;

  always_comb begin
    lvl_c  = (lvl_i  > TOP) ? TOP : lvl_i;
    gate_c = (gate_i > TOP) ? TOP : gate_i;
    inv    = TOP - lvl_c;
    req_o  = (inv < gate_c) ? inv : gate_c;
  end
endmodule

// File: rtl/tern_next.sv
module tern_next
  import tern_pkg::*;
#(
  parameter int K = 3,
  parameter int W = $clog2(K)
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] up_req_i,
  input  logic [W-1:0] sw_req_i,
  input  logic [W-1:0] dn_req_i,
  output logic [W-1:0] nxt_o,
  output logic         bad_o
);
  localparam logic [W:0] TOP = (W+1)'(K-1);
  tern_act_e    act;
  logic [W:0]   room, up, dn, sum;

  always_comb begin
    if ((up_req_i != '0) && (sw_req_i != '0) && (dn_req_i != '0))
      act = ACT_BAD;
    else if (sw_req_i != '0)
      act = ACT_SWING;
    else if ((up_req_i != '0) || (dn_req_i != '0))
      act = ACT_STEP;
    else
      act = ACT_KEEP;

    room = TOP - {1'b0, state_i};
    up   = ({1'b0, up_req_i} > room) ? room : {1'b0, up_req_i};
    dn   = (dn_req_i > state_i) ? {1'b0, state_i} : {1'b0, dn_req_i};
    sum  = {1'b0, state_i} + up - dn;

    unique case (act)
      ACT_SWING: nxt_o = sw_req_i;
      ACT_STEP:  nxt_o = sum[W-1:0];
      default:   nxt_o = state_i;
    endcase
    bad_o = (act == ACT_BAD);
  end
endmodule

// File: rtl/tern_rotator.sv
module tern_rotator #(
  parameter int K = 3,
  parameter int W = $clog2(K)
) (
  input  logic [W-1:0]   base_i,
  input  logic [W-1:0]   rot_i,
  output logic [K*W-1:0] taps_o
);
  localparam logic [W:0] KV = (W+1)'(K);

  function automatic logic [W-1:0] add_mod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (t >= KV) t = t - KV;
    return t[W-1:0];
  endfunction

  logic [W-1:0] step;
  logic [W-1:0] chain [K];

  always_comb begin
    step = ({1'b0, rot_i} >= KV) ? W'({1'b0, rot_i} - KV) : rot_i;
  end

  assign chain[0] = base_i;
  assign taps_o[W-1:0] = chain[0];

  genvar j;
  generate
    for (j = 1; j < K; j++) begin : g_tap
      assign chain[j] = add_mod(chain[j-1], step);
      assign taps_o[j*W +: W] = chain[j];
    end
  endgenerate
endmodule

// File: rtl/tern_rs_cell.sv
module tern_rs_cell #(
  parameter int K = 3,
  parameter int W = $clog2(K)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   s_lvl_i,
  input  logic [W-1:0]   sr_lvl_i,
  input  logic [W-1:0]   r_lvl_i,
  input  logic [W-1:0]   gate_i,
  input  logic [W-1:0]   rot_i,
  output logic [K*W-1:0] taps_o,
  output logic           err_o
);
  localparam int NCTL = 3;

  logic [W-1:0]   lvl [NCTL];
  logic [W-1:0]   req [NCTL];
  logic [W-1:0]   state_q, nxt, base;
  logic           bad;
  logic [K*W-1:0] taps_d, taps_q;
  logic           err_q;

  assign lvl[0] = s_lvl_i;
  assign lvl[1] = sr_lvl_i;
  assign lvl[2] = r_lvl_i;

  genvar n;
  generate
    for (n = 0; n < NCTL; n++) begin : g_gate
      tern_gate #(.K(K), .W(W)) u_gate (
        .lvl_i (lvl[n]),
        .gate_i(gate_i),
        .req_o (req[n])
      );
    end
  endgenerate

  tern_next #(.K(K), .W(W)) u_next (
    .state_i (state_q),
    .up_req_i(req[0]),
    .sw_req_i(req[1]),
    .dn_req_i(req[2]),
    .nxt_o   (nxt),
    .bad_o   (bad)
  );

  assign base = rst ? '0 : nxt;

  tern_rotator #(.K(K), .W(W)) u_rot (
    .base_i(base),
    .rot_i (rot_i),
    .taps_o(taps_d)
  );

  always_ff @(posedge clk) begin
    state_q <= base;
    taps_q  <= taps_d;
    err_q   <= rst ? 1'b0 : bad;
  end

  assign taps_o = taps_q;
  assign err_o  = err_q;
endmodule

// File: rtl/tern_rs_cell_chk.sv
module tern_rs_cell_chk #(
  parameter int K = 3,
  parameter int W = $clog2(K)
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   s_lvl_i,
  input logic [W-1:0]   sr_lvl_i,
  input logic [W-1:0]   r_lvl_i,
  input logic [W-1:0]   gate_i,
  input logic [W-1:0]   rot_i,
  input logic [K*W-1:0] taps_o,
  input logic           err_o
);
  localparam logic [W:0] KV  = (W+1)'(K);
  localparam logic [W-1:0] TOP = W'(K-1);

  logic [W-1:0] tap0;
  assign tap0 = taps_o[W-1:0];

  function automatic logic [W-1:0] red(input logic [W-1:0] r);
    return ({1'b0, r} >= KV) ? W'({1'b0, r} - KV) : r;
  endfunction

  function automatic logic [W-1:0] addm(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (t >= KV) t = t - KV;
    return t[W-1:0];
  endfunction

  AST_GATE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (gate_i == '0) |=> ($stable(tap0) && !err_o)); // R3

  AST_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((s_lvl_i >= TOP) && (sr_lvl_i >= TOP) && (r_lvl_i >= TOP)) |=> ($stable(tap0) && !err_o)); // R2

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past((gate_i != '0) && (s_lvl_i < TOP) && (sr_lvl_i < TOP) && (r_lvl_i < TOP))); // R7

  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(tap0)); // R7

  generate
    if (K > 1) begin : g_rot
      AST_TAP_ROT: assert property (@(posedge clk) disable iff (rst)
        taps_o[2*W-1:W] == addm(tap0, red($past(rot_i)))); // R8
    end
    for (genvar j = 0; j < K; j++) begin : g_rng
      AST_TAP_RANGE: assert property (@(posedge clk) disable iff (rst)
        {1'b0, taps_o[j*W +: W]} < KV); // R9
    end
  endgenerate
endmodule

bind tern_rs_cell tern_rs_cell_chk #(.K(K), .W(W)) u_chk (
  .clk(clk), .rst(rst), .s_lvl_i(s_lvl_i), .sr_lvl_i(sr_lvl_i), .r_lvl_i(r_lvl_i),
  .gate_i(gate_i), .rot_i(rot_i), .taps_o(taps_o), .err_o(err_o)
);

// File: tb/tern_rs_cell_tb.sv
module tern_rs_cell_tb;
  localparam int K = 3;
  localparam int W = 2;

  logic           clk = 0;
  logic           rst = 1;
  logic [W-1:0]   s_lvl = 2, sr_lvl = 2, r_lvl = 2, gate = 2, rot = 0;
  logic [K*W-1:0] taps;
  logic           err;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int ms = 0;

  typedef struct { logic [K*W-1:0] taps; logic err; string tag; } exp_t;
  exp_t sbq [$];

  always #4 clk = ~clk;

  tern_rs_cell #(.K(K), .W(W)) u_dut (
    .clk(clk), .rst(rst), .s_lvl_i(s_lvl), .sr_lvl_i(sr_lvl), .r_lvl_i(r_lvl),
    .gate_i(gate), .rot_i(rot), .taps_o(taps), .err_o(err)
  );

  function automatic int reqof(int v, int c);
    int lv, cg, rq;
    lv = (v > K-1) ? K-1 : v;
    cg = (c > K-1) ? K-1 : c;
    rq = (K-1) - lv;
    return (rq < cg) ? rq : cg;
  endfunction

  task automatic drive(input bit r_i, input int s, input int sr, input int r, input int c,
                       input int ro, input string tag);
    exp_t e;
    int us, uw, ud, a, b, rr;
    @(negedge clk);
    rst = r_i; s_lvl = W'(s); sr_lvl = W'(sr); r_lvl = W'(r); gate = W'(c); rot = W'(ro);
    us = reqof(s, c); uw = reqof(sr, c); ud = reqof(r, c);
    e.err = 0;
    if (r_i) ms = 0;
    else if (us != 0 && uw != 0 && ud != 0) e.err = 1;
    else if (uw != 0) ms = uw;
    else begin
      a = (us < K-1-ms) ? us : K-1-ms;
      b = (ud < ms) ? ud : ms;
      ms = ms + a - b;
    end
    rr = ro % K;
    for (int j = 0; j < K; j++) e.taps[j*W +: W] = W'((ms + j*rr) % K);
    e.tag = tag;
    sbq.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      n_run++;
      if (taps !== e.taps || err !== e.err) begin
        n_fail++;
        $display("FAIL %s: taps=%h err=%b expected taps=%h err=%b", e.tag, taps, err, e.taps, e.err);
      end
      n_run++;
      for (int j = 0; j < K; j++)
        if (taps[j*W +: W] >= K) begin
          n_fail++;
          $display("FAIL R9: tap%0d=%0d expected <%0d", j, taps[j*W +: W], K);
        end
    end
  end

  initial begin
    drive(1, 2, 2, 2, 2, 1, "R1 reset rot1");
    drive(0, 2, 2, 2, 2, 0, "R2 all idle");
    drive(0, 1, 2, 2, 2, 0, "R4 raise by 1");
    drive(0, 0, 2, 2, 2, 0, "R4 raise saturates");
    drive(0, 0, 2, 2, 2, 0, "R4 no wrap at top");
    drive(0, 2, 2, 1, 2, 0, "R5 lower by 1");
    drive(0, 2, 2, 0, 2, 0, "R5 lower saturates");
    drive(0, 2, 2, 0, 2, 0, "R5 no wrap at bottom");
    drive(0, 2, 0, 2, 2, 0, "R6 swing to 2");
    drive(0, 0, 1, 2, 2, 0, "R6 swing overrides raise");
    drive(0, 1, 2, 0, 2, 0, "R5 raise and lower");
    drive(0, 1, 1, 1, 2, 0, "R7 illegal holds");
    drive(0, 2, 2, 2, 2, 0, "R7 flag clears");
    drive(0, 0, 0, 0, 0, 0, "R3 gate 0 locks");
    drive(0, 0, 2, 2, 1, 0, "R3 gate 1 limits raise");
    drive(0, 2, 2, 0, 1, 0, "R3 gate 1 limits lower");
    drive(0, 2, 2, 2, 2, 1, "R8 rot 1");
    drive(0, 2, 2, 2, 2, 2, "R8 rot 2");
    drive(0, 2, 2, 2, 2, 3, "R8 rot 3 reduced");
    drive(0, 3, 3, 3, 2, 0, "R2 code 3 is idle");
    drive(1, 0, 0, 0, 2, 2, "R1 reset rot2");
    drive(0, 2, 2, 2, 2, 0, "R2 idle after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule